// File: doc/BRIEF.md
# DRAM Self-Refresh and Calibration Sequencer

This block drives the clock-enable level of a DRAM device and issues the commands that surround reset release, self-refresh and impedance (ZQ) calibration. When the device's reset has been released, it raises clock enable, waits out the exit delay and then issues the initial long calibration. After that it opens the device to traffic. From the ready state it accepts a request to enter self-refresh, or a request for a long or short calibration. Each of these runs for a counted number of cycles, and during that time the ready flags stay low.

Self-refresh exit is released in two steps. First a flag opens the device to commands that need no locked DLL. Later a second flag opens it to every command, once the DLL lock time has elapsed from the clock-enable rise. While the device sits in self-refresh, a separate flag tells the clock generator that it may stop the clock. That flag is raised only after the clock has stayed valid long enough after entry. It falls on an exit request, a fixed number of cycles before clock enable rises again. A calibration request that arrives while the device is not ready is held, and it is started once full readiness returns. All delays given in nanoseconds are turned into cycles by ceiling division by the clock period parameter.

Top module: `sr_zq_seq`

## Requirements
- R1: While `reset_done` has not yet been seen after reset, `cke`, `clk_stop_ok`, `nodll_ok`, `all_ok` and all four command outputs are 0.
- R2: `cke` rises one cycle after a `reset_done` pulse. The initial `zq_long_cmd` follows exactly XPR = max(5, REFRESH_CYC + ceil(10 ns / tCK)) cycles after that rise.
- R3: `nodll_ok` and `all_ok` rise together exactly ZQ_INIT_CYC (512) cycles after the initial calibration command.
- R4: In the ready state, a one-cycle request pulse on `zq_long_req` or `zq_short_req` yields a one-cycle command pulse two cycles later. Both ready flags are low from that cycle on, for exactly ZQ_LONG_CYC (256) or ZQ_SHORT_CYC (64) cycles. At most one command output is high in any cycle.
- R5: A self-refresh entry request in the ready state produces a one-cycle `sre_cmd` in the next cycle, and `cke` falls in that same cycle. `clk_stop_ok` rises exactly max(HOLD, CKE_MIN_CYC + 1) cycles after `cke` falls, where HOLD = max(5, ceil(10 ns / tCK)).
- R6: An exit request while `clk_stop_ok` is high drops `clk_stop_ok` in the next cycle. `cke` rises, together with a one-cycle `srx_cmd`, exactly HOLD cycles after that drop.
- R7: An exit request is ignored unless `clk_stop_ok` is high. An entry request is ignored unless `all_ok` is high.
- R8: After self-refresh exit, `nodll_ok` rises exactly XS = max(5, REFRESH_CYC + ceil(10 ns / tCK)) cycles after `cke` rises, while `all_ok` is still low.
- R9: After self-refresh exit, `all_ok` rises exactly DLLK_CYC (512) cycles after `cke` rises. `all_ok` is never high without `nodll_ok`.
- R10: A calibration request made while `all_ok` is low is held. Its command is issued in the cycle after `all_ok` next rises, and a short calibration command is never issued unless `all_ok` was high in the cycle before.
- R11: In the ready state, a self-refresh entry request wins over held calibration requests, and a long calibration wins over a short one. Issuing a long calibration discards a held short request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reset_done | input | 1 | Pulse: device reset has been released |
| sr_enter_req | input | 1 | Pulse: request to enter self-refresh |
| sr_exit_req | input | 1 | Pulse: request to leave self-refresh |
| zq_long_req | input | 1 | Pulse: request a long calibration |
| zq_short_req | input | 1 | Pulse: request a short calibration |
| cke | output | 1 | Clock-enable level for the device |
| clk_stop_ok | output | 1 | The device clock may be stopped |
| nodll_ok | output | 1 | Commands that need no locked DLL are allowed |
| all_ok | output | 1 | Any command is allowed |
| zq_long_cmd | output | 1 | Issue a long calibration command this cycle |
| zq_short_cmd | output | 1 | Issue a short calibration command this cycle |
| sre_cmd | output | 1 | Issue the self-refresh entry command this cycle |
| srx_cmd | output | 1 | Self-refresh exit: clock enable rises this cycle |

## Verification
The checker watches every cycle for a minimum window that is cut short. It counts the cycles since the last clock-enable rise, since clock enable fell and since the clock-stop flag dropped. From these counts it checks that no ready flag, stop flag or exit comes too early. It also checks that commands never overlap, that a short calibration only follows full readiness and that the ready flags fall under a calibration. Only the bench scenarios can show that each window is exact rather than merely long enough. The same holds for held requests surviving a whole self-refresh, for ignored entry and exit pulses having no effect, and for the long-over-short discard.

// File: rtl/sr_zq_pkg.sv
package sr_zq_pkg;

   typedef enum logic [3:0] {
      ST_RESET_WAIT,
      ST_INIT_ZQ,
      ST_IDLE,
      ST_SR_ENTER,
      ST_SR_ACTIVE,
      ST_SR_WAKE,
      ST_SR_EXIT_EARLY,
      ST_SR_EXIT_FULL,
      ST_ZQ_BUSY
   } seq_state_t;

   localparam int unsigned FLOOR_NCK = 5;
   localparam int unsigned GUARD_NS  = 10;

   function automatic int unsigned div_up(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // nanoseconds to whole cycles, rounded up
   function automatic int unsigned ns_cycles(input int unsigned ns, input int unsigned tck_ps);
      return div_up(ns * 1000, tck_ps);
   endfunction

   // wait after clock enable rises (reset exit or self-refresh exit)
   function automatic int unsigned exit_wait(input int unsigned rfc, input int unsigned tck_ps);
      return max_of(FLOOR_NCK, rfc + ns_cycles(GUARD_NS, tck_ps));
   endfunction

   // clock must stay valid this long around entry and exit
   function automatic int unsigned clk_guard(input int unsigned tck_ps);
      return max_of(FLOOR_NCK, ns_cycles(GUARD_NS, tck_ps));
   endfunction

endpackage

// File: rtl/sr_zq_timer.sv
module sr_zq_timer #(
   parameter int unsigned CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          done
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sr_zq_req_hold.sv
// Holds request pulses until taken. A higher index wins; taking one kind
// also drops every held request of a lower index.
module sr_zq_req_hold #(
   parameter int unsigned KINDS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KINDS-1:0] req,
   input  logic [KINDS-1:0] take,
   output logic [KINDS-1:0] grant
);

   logic [KINDS-1:0] pend_q;
   logic [KINDS:0]   pend_above;
   logic [KINDS:0]   take_above;

   assign pend_above[KINDS] = 1'b0;
   assign take_above[KINDS] = 1'b0;

   for (genvar k = 0; k < KINDS; k++) begin : g_kind
      assign pend_above[k] = pend_above[k+1] | pend_q[k];
      assign take_above[k] = take_above[k+1] | take[k];
      assign grant[k]      = pend_q[k] & ~pend_above[k+1];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q[k] <= 1'b0;
         end else begin
            pend_q[k] <= (pend_q[k] & ~take_above[k]) | req[k];
         end
      end
   end

endmodule

// File: rtl/sr_zq_outdec.sv
module sr_zq_outdec
   import sr_zq_pkg::*;
(
   input  seq_state_t st,
   input  logic       armed,
   output logic       cke,
   output logic       clk_stop_ok,
   output logic       nodll_ok,
   output logic       all_ok
);

   always_comb begin
      cke         = armed;
      clk_stop_ok = 1'b0;
      nodll_ok    = 1'b0;
      all_ok      = 1'b0;
      case (st)
         ST_SR_ENTER, ST_SR_WAKE: cke = 1'b0;
         ST_SR_ACTIVE: begin
            cke         = 1'b0;
            clk_stop_ok = 1'b1;
         end
         ST_SR_EXIT_FULL: nodll_ok = 1'b1;
         ST_IDLE: begin
            nodll_ok = 1'b1;
            all_ok   = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sr_zq_seq.sv
module sr_zq_seq
   import sr_zq_pkg::*;
#(
   parameter int unsigned CLK_PS       = 1250,
   parameter int unsigned REFRESH_CYC  = 208,
   parameter int unsigned CKE_MIN_CYC  = 4,
   parameter int unsigned DLLK_CYC     = 512,
   parameter int unsigned ZQ_INIT_CYC  = 512,
   parameter int unsigned ZQ_LONG_CYC  = 256,
   parameter int unsigned ZQ_SHORT_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reset_done,
   input  logic sr_enter_req,
   input  logic sr_exit_req,
   input  logic zq_long_req,
   input  logic zq_short_req,
   output logic cke,
   output logic clk_stop_ok,
   output logic nodll_ok,
   output logic all_ok,
   output logic zq_long_cmd,
   output logic zq_short_cmd,
   output logic sre_cmd,
   output logic srx_cmd
);

   localparam int unsigned XPR_CYC    = exit_wait(REFRESH_CYC, CLK_PS);
   localparam int unsigned XS_CYC     = exit_wait(REFRESH_CYC, CLK_PS);
   localparam int unsigned HOLD_CYC   = clk_guard(CLK_PS);
   localparam int unsigned SR_MIN_CYC = max_of(HOLD_CYC, CKE_MIN_CYC + 1);
   localparam int unsigned FULL_CYC   = DLLK_CYC - XS_CYC;
   localparam int unsigned BIG_CYC    = max_of(max_of(max_of(XPR_CYC, ZQ_INIT_CYC),
                                               max_of(ZQ_LONG_CYC, ZQ_SHORT_CYC)),
                                               max_of(SR_MIN_CYC, DLLK_CYC));
   localparam int unsigned CW         = $clog2(BIG_CYC + 1);

   localparam logic [CW-1:0] LD_XPR   = CW'(XPR_CYC - 1);
   localparam logic [CW-1:0] LD_INIT  = CW'(ZQ_INIT_CYC - 1);
   localparam logic [CW-1:0] LD_LONG  = CW'(ZQ_LONG_CYC - 1);
   localparam logic [CW-1:0] LD_SHORT = CW'(ZQ_SHORT_CYC - 1);
   localparam logic [CW-1:0] LD_SRMIN = CW'(SR_MIN_CYC - 1);
   localparam logic [CW-1:0] LD_HOLD  = CW'(HOLD_CYC - 1);
   localparam logic [CW-1:0] LD_XS    = CW'(XS_CYC - 1);
   localparam logic [CW-1:0] LD_FULL  = CW'(FULL_CYC - 1);

   // elaboration-time parameter checks
   if (CLK_PS == 0) begin : g_bad_clk
      $error("sr_zq_seq: CLK_PS must be non-zero");
   end
   if (DLLK_CYC <= XS_CYC) begin : g_bad_dllk
      $error("sr_zq_seq: DLL lock time must exceed the early exit window");
   end
   if (ZQ_INIT_CYC == 0 || ZQ_LONG_CYC == 0 || ZQ_SHORT_CYC == 0) begin : g_bad_zq
      $error("sr_zq_seq: calibration lengths must be non-zero");
   end

   seq_state_t    st_q, st_d;
   logic          armed_q, arm_set;
   logic          t_load, t_done;
   logic [CW-1:0] t_val;
   logic [1:0]    zq_req, zq_take, zq_grant;   // index 1 = long, 0 = short
   logic          c_long, c_short, c_sre, c_srx;

   assign zq_req = {zq_long_req, zq_short_req};

   sr_zq_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   sr_zq_req_hold #(.KINDS(2)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (zq_req),
      .take  (zq_take),
      .grant (zq_grant)
   );

   sr_zq_outdec u_dec (
      .st          (st_q),
      .armed       (armed_q),
      .cke         (cke),
      .clk_stop_ok (clk_stop_ok),
      .nodll_ok    (nodll_ok),
      .all_ok      (all_ok)
   );

   always_comb begin
      st_d    = st_q;
      t_load  = 1'b0;
      t_val   = '0;
      arm_set = 1'b0;
      zq_take = '0;
      c_long  = 1'b0;
      c_short = 1'b0;
      c_sre   = 1'b0;
      c_srx   = 1'b0;
      case (st_q)
         ST_RESET_WAIT: begin
            if (!armed_q) begin
               if (reset_done) begin
                  arm_set = 1'b1;
                  t_load  = 1'b1;
                  t_val   = LD_XPR;
               end
            end else if (t_done) begin
               st_d   = ST_INIT_ZQ;
               t_load = 1'b1;
               t_val  = LD_INIT;
               c_long = 1'b1;
            end
         end
         ST_INIT_ZQ: begin
            if (t_done) st_d = ST_IDLE;
         end
         ST_IDLE: begin
            if (sr_enter_req) begin
               st_d   = ST_SR_ENTER;
               t_load = 1'b1;
               t_val  = LD_SRMIN;
               c_sre  = 1'b1;
            end else if (zq_grant[1]) begin
               st_d       = ST_ZQ_BUSY;
               t_load     = 1'b1;
               t_val      = LD_LONG;
               zq_take[1] = 1'b1;
               c_long     = 1'b1;
            end else if (zq_grant[0]) begin
               st_d       = ST_ZQ_BUSY;
               t_load     = 1'b1;
               t_val      = LD_SHORT;
               zq_take[0] = 1'b1;
               c_short    = 1'b1;
            end
         end
         ST_SR_ENTER: begin
            if (t_done) st_d = ST_SR_ACTIVE;
         end
         ST_SR_ACTIVE: begin
            if (sr_exit_req) begin
               st_d   = ST_SR_WAKE;
               t_load = 1'b1;
               t_val  = LD_HOLD;
            end
         end
         ST_SR_WAKE: begin
            if (t_done) begin
               st_d   = ST_SR_EXIT_EARLY;
               t_load = 1'b1;
               t_val  = LD_XS;
               c_srx  = 1'b1;
            end
         end
         ST_SR_EXIT_EARLY: begin
            if (t_done) begin
               st_d   = ST_SR_EXIT_FULL;
               t_load = 1'b1;
               t_val  = LD_FULL;
            end
         end
         ST_SR_EXIT_FULL: begin
            if (t_done) st_d = ST_IDLE;
         end
         ST_ZQ_BUSY: begin
            if (t_done) st_d = ST_IDLE;
         end
         default: st_d = ST_RESET_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_RESET_WAIT;
         armed_q      <= 1'b0;
         zq_long_cmd  <= 1'b0;
         zq_short_cmd <= 1'b0;
         sre_cmd      <= 1'b0;
         srx_cmd      <= 1'b0;
      end else begin
         st_q         <= st_d;
         armed_q      <= armed_q | arm_set;
         zq_long_cmd  <= c_long;
         zq_short_cmd <= c_short;
         sre_cmd      <= c_sre;
         srx_cmd      <= c_srx;
      end
   end

endmodule

// File: rtl/sr_zq_chk.sv
module sr_zq_chk
   import sr_zq_pkg::*;
#(
   parameter int unsigned CLK_PS       = 1250,
   parameter int unsigned REFRESH_CYC  = 208,
   parameter int unsigned CKE_MIN_CYC  = 4,
   parameter int unsigned DLLK_CYC     = 512
) (
   input logic clk,
   input logic rst_n,
   input logic cke,
   input logic clk_stop_ok,
   input logic nodll_ok,
   input logic all_ok,
   input logic zq_long_cmd,
   input logic zq_short_cmd,
   input logic sre_cmd,
   input logic srx_cmd
);

   localparam int unsigned XS_CYC     = exit_wait(REFRESH_CYC, CLK_PS);
   localparam int unsigned HOLD_CYC   = clk_guard(CLK_PS);
   localparam int unsigned SR_MIN_CYC = max_of(HOLD_CYC, CKE_MIN_CYC + 1);
   localparam logic [15:0] SAT        = 16'hFFFF;

   logic        cke_d, stop_d;
   logic [15:0] since_rise, low_cnt, since_stop_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cke_d           <= 1'b0;
         stop_d          <= 1'b0;
         since_rise      <= '0;
         low_cnt         <= '0;
         since_stop_fall <= '0;
      end else begin
         cke_d  <= cke;
         stop_d <= clk_stop_ok;
         if (cke && !cke_d)          since_rise <= 16'd1;
         else if (since_rise != SAT) since_rise <= since_rise + 16'd1;
         if (cke)                    low_cnt <= '0;
         else if (low_cnt != SAT)    low_cnt <= low_cnt + 16'd1;
         if (!clk_stop_ok && stop_d)      since_stop_fall <= 16'd1;
         else if (since_stop_fall != SAT) since_stop_fall <= since_stop_fall + 16'd1;
      end
   end

   assert_nodll_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nodll_ok) |-> since_rise >= 16'(XS_CYC));

   assert_all_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(all_ok) |-> since_rise >= 16'(DLLK_CYC));

   assert_ready_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
      all_ok |-> nodll_ok);

   assert_cke_low_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      srx_cmd |-> ($rose(cke) && low_cnt >= 16'(CKE_MIN_CYC + 1)));

   assert_stop_after_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_stop_ok) |-> low_cnt >= 16'(SR_MIN_CYC));

   assert_clk_before_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      srx_cmd |-> since_stop_fall >= 16'(HOLD_CYC));

   assert_single_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({zq_long_cmd, zq_short_cmd, sre_cmd, srx_cmd}));

   assert_zq_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (zq_long_cmd || zq_short_cmd) |=> !all_ok);

   assert_short_after_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      zq_short_cmd |-> $past(all_ok));

endmodule

bind sr_zq_seq sr_zq_chk #(
   .CLK_PS      (CLK_PS),
   .REFRESH_CYC (REFRESH_CYC),
   .CKE_MIN_CYC (CKE_MIN_CYC),
   .DLLK_CYC    (DLLK_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cke          (cke),
   .clk_stop_ok  (clk_stop_ok),
   .nodll_ok     (nodll_ok),
   .all_ok       (all_ok),
   .zq_long_cmd  (zq_long_cmd),
   .zq_short_cmd (zq_short_cmd),
   .sre_cmd      (sre_cmd),
   .srx_cmd      (srx_cmd)
);

// File: tb/tb_sr_zq_seq.sv
module tb_sr_zq_seq;

   localparam int TCK_PS  = 20000;
   localparam int RFC     = 14;
   localparam int CKE_MIN = 6;
   localparam int DLLK    = 512;
   localparam int ZQI     = 512;
   localparam int ZQL     = 256;
   localparam int ZQS     = 64;

   // signal codes for wait_for
   localparam int S_CKE = 0, S_NODLL = 1, S_ALL = 2, S_STOP = 3,
                  S_ZQL = 4, S_ZQS = 5, S_SRE = 6, S_SRX = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reset_done = 1'b0, sr_enter_req = 1'b0, sr_exit_req = 1'b0;
   logic zq_long_req = 1'b0, zq_short_req = 1'b0;
   logic cke, clk_stop_ok, nodll_ok, all_ok;
   logic zq_long_cmd, zq_short_cmd, sre_cmd, srx_cmd;

   int n_tests = 0, n_fail = 0, cyc = 0;
   bit done_flag = 1'b0;

   sr_zq_seq #(
      .CLK_PS(TCK_PS), .REFRESH_CYC(RFC), .CKE_MIN_CYC(CKE_MIN),
      .DLLK_CYC(DLLK), .ZQ_INIT_CYC(ZQI), .ZQ_LONG_CYC(ZQL), .ZQ_SHORT_CYC(ZQS)
   ) dut (.*);

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   function automatic int cdiv(input int a, input int b);
      return (a + b - 1) / b;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   function automatic int exp_xs();
      return imax(5, RFC + cdiv(10000, TCK_PS));
   endfunction
   function automatic int exp_hold();
      return imax(5, cdiv(10000, TCK_PS));
   endfunction
   function automatic int exp_srmin();
      return imax(exp_hold(), CKE_MIN + 1);
   endfunction

   function automatic logic sig(input int w);
      case (w)
         S_CKE:   return cke;
         S_NODLL: return nodll_ok;
         S_ALL:   return all_ok;
         S_STOP:  return clk_stop_ok;
         S_ZQL:   return zq_long_cmd;
         S_ZQS:   return zq_short_cmd;
         S_SRE:   return sre_cmd;
         default: return srx_cmd;
      endcase
   endfunction

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wait_for(input int w, input logic lvl, input string req, output int t);
      int guard = 0;
      t = -1;
      while (guard < 3000) begin
         @(negedge clk);
         if (sig(w) == lvl) begin
            t = cyc;
            return;
         end
         guard++;
      end
      check_eq(req, "timeout waiting on output", 0, 1);
   endtask

   task automatic run_zq(input bit is_long);
      int tr, tc, ta;
      @(negedge clk);
      if (is_long) zq_long_req = 1'b1; else zq_short_req = 1'b1;
      tr = cyc;
      @(negedge clk);
      zq_long_req = 1'b0; zq_short_req = 1'b0;
      wait_for(is_long ? S_ZQL : S_ZQS, 1'b1, "R4", tc);
      check_eq("R4", "request to command", tc - tr, 2);
      check_eq("R4", "all_ok low at command", int'(all_ok), 0);
      @(negedge clk);
      check_eq("R4", "command one cycle", int'(is_long ? zq_long_cmd : zq_short_cmd), 0);
      wait_for(S_ALL, 1'b1, "R4", ta);
      check_eq("R4", "calibration length", ta - tc, is_long ? ZQL : ZQS);
   endtask

   task automatic run_sr(input bit with_zq, input bit probe_exit, input int dwell);
      int tr, ts, tx, tf, tc, tn, ta, tz;
      @(negedge clk);
      sr_enter_req = 1'b1; zq_short_req = with_zq;
      tr = cyc;
      @(negedge clk);
      sr_enter_req = 1'b0; zq_short_req = 1'b0;
      check_eq("R5", "sre_cmd after entry request", int'(sre_cmd), 1);
      check_eq("R5", "cke falls with sre_cmd", int'(cke), 0);
      check_eq("R11", "entry wins over calibration", int'(zq_short_cmd), 0);
      if (probe_exit) begin
         sr_exit_req = 1'b1;            // during entry window: must be ignored
         @(negedge clk);
         sr_exit_req = 1'b0;
      end
      wait_for(S_STOP, 1'b1, "R5", ts);
      check_eq("R5", "entry to clk_stop_ok", ts - (tr + 1), exp_srmin());
      if (probe_exit) check_eq("R7", "early exit ignored, cke low", int'(cke), 0);
      repeat (dwell) @(negedge clk);
      check_eq("R7", "clk_stop_ok held in self-refresh", int'(clk_stop_ok), 1);
      sr_exit_req = 1'b1;
      tx = cyc;
      @(negedge clk);
      sr_exit_req = 1'b0;
      tf = (clk_stop_ok == 1'b0) ? cyc : -1;
      check_eq("R6", "clk_stop_ok drop after exit request", tf - tx, 1);
      wait_for(S_CKE, 1'b1, "R6", tc);
      check_eq("R6", "clock hold before cke rise", tc - tf, exp_hold());
      check_eq("R6", "srx_cmd with cke rise", int'(srx_cmd), 1);
      wait_for(S_NODLL, 1'b1, "R8", tn);
      check_eq("R8", "cke rise to nodll_ok", tn - tc, exp_xs());
      check_eq("R8", "all_ok still low", int'(all_ok), 0);
      wait_for(S_ALL, 1'b1, "R9", ta);
      check_eq("R9", "cke rise to all_ok", ta - tc, DLLK);
      if (with_zq) begin
         wait_for(S_ZQS, 1'b1, "R10", tz);
         check_eq("R10", "held short issued after ready", tz - ta, 1);
         wait_for(S_ALL, 1'b1, "R10", ta);
         check_eq("R10", "held short length", ta - tz, ZQS);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         check_eq("WD", "watchdog expired", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      int t0, t1, t2, any, ta;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1: idle before reset_done
      check_eq("R1", "cke before reset_done", int'(cke), 0);
      check_eq("R1", "flags before reset_done",
               int'({clk_stop_ok, nodll_ok, all_ok}), 0);
      check_eq("R1", "commands before reset_done",
               int'({zq_long_cmd, zq_short_cmd, sre_cmd, srx_cmd}), 0);

      reset_done = 1'b1; t0 = cyc;
      @(negedge clk);
      reset_done = 1'b0;
      check_eq("R2", "cke one cycle after reset_done", cyc - t0, 1);
      check_eq("R2", "cke high", int'(cke), 1);
      t0 = cyc;
      wait_for(S_ZQL, 1'b1, "R2", t1);
      check_eq("R2", "cke rise to first command", t1 - t0, exp_xs());
      wait_for(S_ALL, 1'b1, "R3", t2);
      check_eq("R3", "init calibration length", t2 - t1, ZQI);
      check_eq("R3", "nodll_ok with all_ok", int'(nodll_ok), 1);

      run_zq(1'b1);
      run_zq(1'b0);

      // R7: entry during calibration is ignored
      @(negedge clk); zq_short_req = 1'b1;
      @(negedge clk); zq_short_req = 1'b0;
      wait_for(S_ZQS, 1'b1, "R7", t1);
      sr_enter_req = 1'b1;
      @(negedge clk); sr_enter_req = 1'b0;
      wait_for(S_ALL, 1'b1, "R7", t2);
      repeat (3) @(negedge clk);
      check_eq("R7", "entry during calibration ignored (cke)", int'(cke), 1);
      check_eq("R7", "entry during calibration ignored (all_ok)", int'(all_ok), 1);

      // self-refresh with a held calibration and an early exit probe
      run_sr(1'b1, 1'b1, 20);

      // R11: long beats short, short discarded
      @(negedge clk); zq_long_req = 1'b1; zq_short_req = 1'b1;
      @(negedge clk); zq_long_req = 1'b0; zq_short_req = 1'b0;
      @(negedge clk);
      check_eq("R11", "long issued first", int'(zq_long_cmd), 1);
      check_eq("R11", "short not issued with long", int'(zq_short_cmd), 0);
      wait_for(S_ALL, 1'b1, "R11", ta);
      any = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (zq_short_cmd) any++;
      end
      check_eq("R11", "short discarded by long", any, 0);

      // R10: long request held through self-refresh
      @(negedge clk); sr_enter_req = 1'b1;
      @(negedge clk); sr_enter_req = 1'b0;
      wait_for(S_STOP, 1'b1, "R10", t1);
      zq_long_req = 1'b1;
      @(negedge clk); zq_long_req = 1'b0;
      check_eq("R10", "no calibration in self-refresh", int'(zq_long_cmd), 0);
      sr_exit_req = 1'b1;
      @(negedge clk); sr_exit_req = 1'b0;
      wait_for(S_ALL, 1'b1, "R10", ta);
      @(negedge clk);
      check_eq("R10", "held long issued after ready", int'(zq_long_cmd), 1);
      wait_for(S_ALL, 1'b1, "R10", t2);

      // constrained random mix
      for (int i = 0; i < 8; i++) begin
         int op;
         op = int'($urandom % 3);
         repeat (int'($urandom % 6)) @(negedge clk);
         case (op)
            0: run_zq(1'b1);
            1: run_zq(1'b0);
            default: run_sr(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 30));
         endcase
      end

      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule